// File: doc/BRIEF.md
# Coprocessor Transfer Address Sequencer

This block produces the byte addresses for a coprocessor load or store that moves one or more consecutive words. On a start strobe it captures a base value, an 8-bit word offset, three control bits and a word count. It then presents one transfer address per word, stepping by four bytes each time the memory accepts a word. When the sequence ends, it drives a one-cycle completion pulse together with the base write-back value and its enable.

The base is either the supplied register value or, when the base-is-PC flag is set, the instruction address plus eight. The scaled offset is added or subtracted to form a modified base. The modified base is used as the first address when pre-indexing and is written back when the write-back bit is set. An abort from the memory ends the sequence at once. Write-back still takes place after an abort.

Top module: `cpx_addr_seq`

## Requirements
- R1: After reset, `xferValid`, `donePulse`, `wbEn`, `wbErr`, `abortedSt` and `lastWord` are all low.
- R2: The modified base equals the effective base plus `immOff`×4 when `upBit`=1, and the effective base minus `immOff`×4 when `upBit`=0, modulo 2^32.
- R3: `startStb` is sampled at a clock edge while idle. From the next cycle `xferValid` is high and `xferAddr` holds the first address. The first address is the modified base when `preBit`=1 and the unmodified effective base when `preBit`=0.
- R4: When `baseIsPc`=1, the effective base is `instrAddr`+8 and `baseVal` has no effect.
- R5: Each word after the first is presented at the previous transfer address plus 4.
- R6: The low two bits of the effective base reach `xferAddr` unchanged; no alignment is forced.
- R7: `wordCnt` gives 1 to 15 words, and 0 is treated as 1. `lastWord` is high exactly while the final word's address is presented.
- R8: While `memRdy`=0 and `memAbort`=0, the presented address holds. The sequence advances only on cycles where `memRdy`=1.
- R9: `memAbort`=1 while a word is presented ends the sequence, and it takes priority over `memRdy`. In the next cycle `xferValid` is low and `donePulse` and `abortedSt` are high, and no further words are presented.
- R10: `donePulse` is high for exactly one cycle, in the cycle after the final word is accepted or aborted. In that cycle `wbEn` equals `wbBit` (for a non-PC base) and `wbValue` is the modified base. This holds in both indexing modes and after an abort. `wbValue` is 0 whenever `wbEn` is low.
- R11: With `baseIsPc`=1, `wbEn` stays low. If `wbBit`=1 as well, `wbErr` is high during `donePulse`.
- R12: `startStb` has no effect while `xferValid` or `donePulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startStb | input | 1 | Begin a transfer (sampled while idle) |
| baseVal | input | 32 | Base register value |
| baseIsPc | input | 1 | Base is the program counter |
| instrAddr | input | 32 | Address of the current instruction |
| immOff | input | 8 | Unsigned word offset |
| upBit | input | 1 | 1 = add offset, 0 = subtract |
| preBit | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| wbBit | input | 1 | Request base write-back |
| wordCnt | input | 4 | Number of words (0 treated as 1) |
| memRdy | input | 1 | Memory accepts the presented word this cycle |
| memAbort | input | 1 | Memory aborts the presented word |
| xferAddr | output | 32 | Current transfer byte address |
| xferValid | output | 1 | A word address is presented |
| lastWord | output | 1 | The presented word is the final one |
| wbValue | output | 32 | Base write-back value |
| wbEn | output | 1 | Base write-back enable (one cycle) |
| donePulse | output | 1 | Sequence finished (one cycle) |
| abortedSt | output | 1 | The sequence ended by an abort (with `donePulse`) |
| wbErr | output | 1 | Write-back requested with a PC base (with `donePulse`) |

## Verification
A corrupted address register appears on `xferAddr` in the same cycle it goes wrong, and every later word of that sequence is off by the same amount. A corrupted remaining-word counter shows up as `lastWord` rising early or late. It also shows up as `donePulse` arriving a word early, or as extra words after the expected last one, within one accepted word. A corrupted stored offset or write-back flag stays hidden until the completion cycle, where `wbValue`, `wbEn` or `wbErr` disagree. The bench therefore compares every presented address, including stalled ones, and every completion item.

// File: rtl/cpx_seq_pkg.sv
package cpx_seq_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;      // capture operands and first address
    logic advance;   // step to next word
    logic endOk;     // final word accepted
    logic endAbort;  // word aborted
  } seqStrobe_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_XFER = 2'd1,
    SQ_DONE = 2'd2
  } seqState_t;

endpackage

// File: rtl/cpx_seq_ctrl.sv
module cpx_seq_ctrl
  import cpx_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStb,
  input  logic       memRdy,
  input  logic       memAbort,
  input  logic       remIsOne,
  output seqStrobe_t stb,
  output logic       xferValid,
  output logic       donePulse
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    unique case (stateQ)
      SQ_IDLE: begin
        if (startStb) begin
          stb.load = 1'b1;
          stateD   = SQ_XFER;
        end
      end
      SQ_XFER: begin
        if (memAbort) begin
          stb.endAbort = 1'b1;
          stateD       = SQ_DONE;
        end else if (memRdy) begin
          if (remIsOne) begin
            stb.endOk = 1'b1;
            stateD    = SQ_DONE;
          end else begin
            stb.advance = 1'b1;
          end
        end
      end
      SQ_DONE: stateD = SQ_IDLE;
      default: stateD = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SQ_IDLE;
    else       stateQ <= stateD;
  end

  assign xferValid = (stateQ == SQ_XFER);
  assign donePulse = (stateQ == SQ_DONE);

  // R10: completion lasts a single cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R12: a start during completion does not launch a new sequence
  assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && startStb) |=> !xferValid);

endmodule

// File: rtl/cpx_seq_dp.sv
module cpx_seq_dp
  import cpx_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IMM_W      = 8,
  parameter int CNT_W      = 4,
  parameter int WORD_BYTES = 4,
  parameter int PC_AHEAD   = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic              baseIsPc,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [IMM_W-1:0]  immOff,
  input  logic              upBit,
  input  logic              preBit,
  input  logic              wbBit,
  input  logic [CNT_W-1:0]  wordCnt,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [ADDR_W-1:0] modBase,
  output logic              remIsOne,
  output logic              wbReq,
  output logic              errReq,
  output logic              abortReq
);

  localparam int SHIFT = $clog2(WORD_BYTES);
  localparam int PAD_W = ADDR_W - IMM_W - SHIFT;
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(PC_AHEAD);
  localparam logic [CNT_W-1:0]  ONE   = CNT_W'(1);

  logic [ADDR_W-1:0] effBase, scaledOff, modNext;
  logic [ADDR_W-1:0] addrQ, modQ;
  logic [CNT_W-1:0]  remQ;
  logic              wbQ, errQ, abortQ;

  assign effBase   = baseIsPc ? (instrAddr + AHEAD) : baseVal;
  assign scaledOff = {{PAD_W{1'b0}}, immOff, {SHIFT{1'b0}}};

  // Offset direction: one adder/subtractor selected per build variant
  generate
    if (SHIFT > 0) begin : gSigned
      assign modNext = upBit ? (effBase + scaledOff) : (effBase - scaledOff);
    end else begin : gByte
      assign modNext = upBit ? (effBase + scaledOff) : (effBase - scaledOff);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      modQ   <= '0;
      remQ   <= ONE;
      wbQ    <= 1'b0;
      errQ   <= 1'b0;
      abortQ <= 1'b0;
    end else begin
      if (stb.load) begin
        addrQ  <= preBit ? modNext : effBase;
        modQ   <= modNext;
        remQ   <= (wordCnt == '0) ? ONE : wordCnt;
        wbQ    <= wbBit & ~baseIsPc;
        errQ   <= wbBit & baseIsPc;
        abortQ <= 1'b0;
      end else if (stb.advance) begin
        addrQ <= addrQ + STEP;
        remQ  <= remQ - ONE;
      end
      if (stb.endAbort) abortQ <= 1'b1;
    end
  end

  assign xferAddr = addrQ;
  assign modBase  = modQ;
  assign remIsOne = (remQ == ONE);
  assign wbReq    = wbQ;
  assign errReq   = errQ;
  assign abortReq = abortQ;

  // R7: the control never steps past the final word
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |-> (remQ > ONE));

  // R11: PC base never yields both write-back and error
  assert_pc_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(wbQ && errQ));

endmodule

// File: rtl/cpx_addr_seq.sv
module cpx_addr_seq
  import cpx_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IMM_W      = 8,
  parameter int CNT_W      = 4,
  parameter int WORD_BYTES = 4,
  parameter int PC_AHEAD   = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic              baseIsPc,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [IMM_W-1:0]  immOff,
  input  logic              upBit,
  input  logic              preBit,
  input  logic              wbBit,
  input  logic [CNT_W-1:0]  wordCnt,
  input  logic              memRdy,
  input  logic              memAbort,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              xferValid,
  output logic              lastWord,
  output logic [ADDR_W-1:0] wbValue,
  output logic              wbEn,
  output logic              donePulse,
  output logic              abortedSt,
  output logic              wbErr
);

  seqStrobe_t        stb;
  logic              remIsOne, wbReq, errReq, abortReq;
  logic [ADDR_W-1:0] modBase;

  cpx_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startStb  (startStb),
    .memRdy    (memRdy),
    .memAbort  (memAbort),
    .remIsOne  (remIsOne),
    .stb       (stb),
    .xferValid (xferValid),
    .donePulse (donePulse)
  );

  cpx_seq_dp #(
    .ADDR_W     (ADDR_W),
    .IMM_W      (IMM_W),
    .CNT_W      (CNT_W),
    .WORD_BYTES (WORD_BYTES),
    .PC_AHEAD   (PC_AHEAD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .baseVal   (baseVal),
    .baseIsPc  (baseIsPc),
    .instrAddr (instrAddr),
    .immOff    (immOff),
    .upBit     (upBit),
    .preBit    (preBit),
    .wbBit     (wbBit),
    .wordCnt   (wordCnt),
    .xferAddr  (xferAddr),
    .modBase   (modBase),
    .remIsOne  (remIsOne),
    .wbReq     (wbReq),
    .errReq    (errReq),
    .abortReq  (abortReq)
  );

  assign lastWord  = xferValid & remIsOne;
  assign wbEn      = donePulse & wbReq;
  assign wbValue   = wbEn ? modBase : '0;
  assign wbErr     = donePulse & errReq;
  assign abortedSt = donePulse & abortReq;

  // R5: an accepted non-final word is followed by the next word address
  assert_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && memRdy && !memAbort && !lastWord)
      |=> (xferValid && xferAddr == $past(xferAddr) + ADDR_W'(WORD_BYTES)));

  // R8: a stalled word keeps its address
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && !memRdy && !memAbort) |=> (xferValid && $stable(xferAddr)));

  // R9: an abort ends the sequence with aborted status
  assert_abort_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && memAbort) |=> (donePulse && abortedSt && !xferValid));

  // R10: the accepted final word leads to a clean completion
  assert_last_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lastWord && memRdy && !memAbort) |=> (donePulse && !abortedSt));

  // R11: an error flag never comes with a write-back
  assert_err_no_wb_R11: assert property (@(posedge clk) disable iff (!rstN)
    wbErr |-> !wbEn);

endmodule

// File: tb/sim_cpx_addr_seq.sv
`timescale 1ns/1ps
module sim_cpx_addr_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStb = 1'b0;
  logic [31:0] baseVal = '0;
  logic        baseIsPc = 1'b0;
  logic [31:0] instrAddr = '0;
  logic [7:0]  immOff = '0;
  logic        upBit = 1'b0, preBit = 1'b0, wbBit = 1'b0;
  logic [3:0]  wordCnt = '0;
  logic        memRdy = 1'b0, memAbort = 1'b0;
  logic [31:0] xferAddr, wbValue;
  logic        xferValid, lastWord, wbEn, donePulse, abortedSt, wbErr;

  always #4 clk = ~clk;  // 125 MHz

  cpx_addr_seq u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .baseVal(baseVal),
    .baseIsPc(baseIsPc), .instrAddr(instrAddr), .immOff(immOff),
    .upBit(upBit), .preBit(preBit), .wbBit(wbBit), .wordCnt(wordCnt),
    .memRdy(memRdy), .memAbort(memAbort), .xferAddr(xferAddr),
    .xferValid(xferValid), .lastWord(lastWord), .wbValue(wbValue),
    .wbEn(wbEn), .donePulse(donePulse), .abortedSt(abortedSt), .wbErr(wbErr)
  );

  typedef struct { logic [31:0] addr; logic last; string tag; } addrItem_t;
  typedef struct { logic en; logic [31:0] val; logic ab; logic err; } doneItem_t;

  addrItem_t addrQ[$];
  doneItem_t doneQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: sample away from the active edge
  always @(negedge clk) begin
    if (running) begin
      if (xferValid) begin
        if (addrQ.size() == 0) begin
          check(1'b0, "R9 R12 unexpected word", xferAddr, 32'hFFFF_FFFF);
        end else begin
          addrItem_t e;
          e = addrQ[0];
          if (!memRdy && !memAbort)
            check(xferAddr == e.addr, "R8 stalled address", xferAddr, e.addr);
          else
            check(xferAddr == e.addr, e.tag, xferAddr, e.addr);
          check(lastWord == e.last, "R7 lastWord", 32'(lastWord), 32'(e.last));
          if (memRdy || memAbort) void'(addrQ.pop_front());
        end
      end
      if (donePulse) begin
        if (doneQ.size() == 0) begin
          check(1'b0, "R10 unexpected done", 32'd1, 32'd0);
        end else begin
          doneItem_t d;
          d = doneQ.pop_front();
          check(addrQ.size() == 0, "R9 R10 words left at done", 32'(addrQ.size()), 32'd0);
          check(wbEn == d.en, "R10 wbEn", 32'(wbEn), 32'(d.en));
          check(wbValue == d.val, "R2 R10 wbValue", wbValue, d.val);
          check(abortedSt == d.ab, "R9 abortedSt", 32'(abortedSt), 32'(d.ab));
          check(wbErr == d.err, "R11 wbErr", 32'(wbErr), 32'(d.err));
        end
      end
    end
  end

  // Driver: computes expectations from the requirements, then drives
  task automatic runTxn(input logic [31:0] base, input bit pc, input logic [31:0] ia,
                        input logic [7:0] imm, input bit u, input bit p, input bit w,
                        input logic [3:0] cnt, input bit stallAlt, input int abortAt,
                        input bit poke);
    logic [31:0] eff, modB, first;
    int n, lastIdx, idx, cyc;
    bit fin, stall;
    doneItem_t d;
    eff   = pc ? ia + 32'd8 : base;
    modB  = u ? eff + {22'd0, imm, 2'b00} : eff - {22'd0, imm, 2'b00};
    first = p ? modB : eff;
    n     = (cnt == 0) ? 1 : int'(cnt);
    lastIdx = (abortAt >= 0 && abortAt < n) ? abortAt : n - 1;
    for (int k = 0; k <= lastIdx; k++) begin
      addrItem_t a;
      a.addr = first + 32'(4 * k);
      a.last = (k == n - 1);
      a.tag  = (k == 0) ? (pc ? "R4 first address" :
                           (base[1:0] != 2'b00 ? "R6 unaligned first" : "R3 first address"))
                        : "R5 next address";
      addrQ.push_back(a);
    end
    d.en  = w && !pc;
    d.val = d.en ? modB : 32'd0;
    d.ab  = (abortAt >= 0 && abortAt < n);
    d.err = w && pc;
    doneQ.push_back(d);

    @(posedge clk); #1;
    startStb = 1'b1; baseVal = base; baseIsPc = pc; instrAddr = ia;
    immOff = imm; upBit = u; preBit = p; wbBit = w; wordCnt = cnt;
    @(posedge clk); #1;
    startStb = 1'b0;
    idx = 0; cyc = 0; fin = 1'b0;
    while (!fin) begin
      stall = stallAlt && (cyc % 2 == 0);
      if (idx == abortAt) begin
        memAbort = 1'b1; memRdy = !stall; fin = 1'b1;
      end else if (stall) begin
        memAbort = 1'b0; memRdy = 1'b0;
      end else begin
        memAbort = 1'b0; memRdy = 1'b1; idx++;
        if (idx == n) fin = 1'b1;
      end
      if (poke && cyc == 1) begin  // R12: start while busy, different operands
        startStb = 1'b1; baseVal = 32'hDEAD_0000; wordCnt = 4'd9;
      end
      @(posedge clk); #1;
      startStb = 1'b0;
      cyc++;
    end
    memRdy = 1'b0; memAbort = 1'b0;
    if (poke) startStb = 1'b1;  // R12: start during the completion cycle
    @(posedge clk); #1;
    startStb = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check({xferValid, donePulse, wbEn, wbErr, abortedSt, lastWord} == 6'b0,
          "R1 reset outputs",
          32'({xferValid, donePulse, wbEn, wbErr, abortedSt, lastWord}), 32'd0);
    rstN = 1'b1;
    running = 1'b1;
    @(posedge clk); #1;

    // pre-indexed up, write-back, 4 words
    runTxn(32'h0000_1000, 0, 0, 8'd3, 1, 1, 1, 4'd4, 0, -1, 0);
    // post-indexed down, no write-back, unaligned base, stalls
    runTxn(32'h0000_2003, 0, 0, 8'd5, 0, 0, 0, 4'd3, 1, -1, 0);
    // post-indexed with write-back, single word
    runTxn(32'h0000_3000, 0, 0, 8'd255, 1, 0, 1, 4'd1, 0, -1, 0);
    // PC base with write-back request: error, no write-back
    runTxn(32'h1234_5678, 1, 32'h0000_8000, 8'd2, 1, 1, 1, 4'd2, 0, -1, 0);
    // PC base without write-back, post-indexed down
    runTxn(32'h1234_5678, 1, 32'h0000_9004, 8'd1, 0, 0, 0, 4'd2, 1, -1, 0);
    // abort on third of five words, write-back still happens; start pokes
    runTxn(32'h0000_4000, 0, 0, 8'd4, 1, 1, 1, 4'd5, 0, 2, 1);
    // zero count behaves as one word
    runTxn(32'h0000_5000, 0, 0, 8'd0, 1, 1, 1, 4'd0, 0, -1, 0);
    // abort on first word during a stall, post-indexed write-back
    runTxn(32'h0000_6000, 0, 0, 8'd8, 0, 0, 1, 4'd3, 1, 0, 0);
    // 15 words, subtraction wraps below zero, stalls
    runTxn(32'h0000_0004, 0, 0, 8'd255, 0, 1, 1, 4'd15, 1, -1, 1);

    repeat (3) @(posedge clk);
    #1;
    check(addrQ.size() == 0 && doneQ.size() == 0, "R10 scoreboard drained",
          32'(addrQ.size() + doneQ.size()), 32'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule